// File: doc/BRIEF.md
# Channel Interrupt Identification Logic

This block turns the raw conditions of a group of serial channels into interrupt causes and a single host interrupt line. Each channel reports its receive FIFO fill level, whether its transmit FIFO is empty, whether a special receive condition is pending, and three modem lines (CTS, DSR, CD). For every channel the block keeps a six-bit cause word. The host can read this word through a channel select, and the read acknowledges the modem-change causes.

The receive cause compares the fill level against a threshold chosen by a two-bit code. A threshold can be one character, half of the FIFO or seven-eighths of the FIFO, and one code disables it. Cause flags record their condition whether or not the matching enable is set. The enables only decide whether a channel counts as interrupting in the group status byte. That byte has one bit per channel. A sticky host interrupt line collects the group status, subject to a global enable, and an end-of-interrupt strobe clears it.

Top module: `chan_int_ident`

## Requirements
- R1: The 2-bit trigger code of a channel selects the receive threshold. Code 0 never triggers. Code 1 triggers at a count ≥ 1. Code 2 triggers at a count ≥ (DEPTH+1)/2, which is 512 by default. Code 3 triggers at a count ≥ (DEPTH+1)·7/8, which is 896 by default. The receive trigger flag follows the comparison one clock after the inputs.
- R2: The receive trigger flag sets whether or not the channel's receive interrupt enable is set.
- R3: The cause word read on `idData` for the channel on `idSel` has these bits: bit 5 is the receive trigger, bit 4 is transmit FIFO empty, bit 3 is the special receive condition, bit 2 is a CD change, bit 1 is a CTS change and bit 0 is a DSR change. The word is valid in the same cycle as `idSel`.
- R4: The transmit-empty and special-condition flags follow their inputs with a one-clock delay. They clear only when the condition goes away, and a read does not clear them.
- R5: A rising or a falling transition of CTS, DSR or CD sets the matching change flag. The input passes through two synchroniser flops, so the flag is set three clocks after the transition.
- R6: An `idRead` pulse clears the three change flags of the selected channel on the next clock. The flags of other channels and the level-based flags are not affected.
- R7: Bit c of `groupStatus` is set when channel c has at least one flag allowed by its enable. The receive trigger is gated by the receive enable, transmit empty by the transmit enable, the special condition by the special enable, and any of the three change flags by the modem enable.
- R8: `hostIrq` is registered. It sets one clock after `hostEn` is high while any `groupStatus` bit is set. It is cleared one clock after `hostEn` is low.
- R9: `hostIrq` stays set after the causes go away, until `eoiStrobe` clears it on the next clock. If causes are still pending, it sets again one clock later.
- R10: After reset all flags are clear, `groupStatus` is 0 and `hostIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLevel | input | N*CW | Receive FIFO fill count per channel, CW bits each |
| txEmpty | input | N | Transmit FIFO empty per channel |
| srcCond | input | N | Special receive condition per channel |
| ctsIn | input | N | CTS modem line per channel (asynchronous) |
| dsrIn | input | N | DSR modem line per channel (asynchronous) |
| cdIn | input | N | CD modem line per channel (asynchronous) |
| trigSel | input | 2*N | Receive trigger code per channel |
| srcIntEn | input | N | Special-condition interrupt enable per channel |
| rxIntEn | input | N | Receive interrupt enable per channel |
| modemIntEn | input | N | Modem change interrupt enable per channel |
| txIntEn | input | N | Transmit interrupt enable per channel |
| idSel | input | SW | Channel whose cause word is presented |
| idRead | input | 1 | Read strobe that acknowledges the selected channel's change flags |
| idData | output | 6 | Cause word of the selected channel |
| groupStatus | output | N | One interrupting bit per channel |
| hostEn | input | 1 | Global enable for the host interrupt |
| eoiStrobe | input | 1 | End-of-interrupt strobe |
| hostIrq | output | 1 | Host interrupt line |

## Verification
The bench uses the default configuration: eight channels and a 1023-entry receive FIFO with 10-bit counts. With these values the real half and seven-eighths boundaries (511/512/513, 895/896/897) can be swept for every trigger code on every channel, and the bench computes the expected values from the depth. Eight channels are enough to show that a read acknowledges only the selected channel. All sixteen enable combinations are applied to one fully loaded channel, and each is checked against the group bit.

// File: rtl/intid_pkg.sv
package intid_pkg;

  // Cause word; field order gives bit positions 5..0
  typedef struct packed {
    logic rxTrig;
    logic txMt;
    logic srcHit;
    logic cdChg;
    logic ctsChg;
    logic dsrChg;
  } idFlags_t;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_ONE   = 2'd1,
    TRIG_HALF  = 2'd2,
    TRIG_SEVEN = 2'd3
  } trigCode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearChanges;
  } ctrlStrobes_t;

endpackage

// File: rtl/intid_line_watch.sv
module intid_line_watch (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic edgeSeen
);
  logic syncA, syncB, histQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      histQ <= 1'b0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      histQ <= syncB;
    end
  end

  assign edgeSeen = syncB ^ histQ;

  // R5: an edge reported now means the history flop moves next cycle
  assert_hist_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> (histQ != $past(histQ)));

endmodule

// File: rtl/intid_datapath.sv
module intid_datapath
  import intid_pkg::*;
#(
  parameter int N     = 8,
  parameter int DEPTH = 1023,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N*CW-1:0] rxLevel,
  input  logic [N-1:0]  txEmpty,
  input  logic [N-1:0]  srcCond,
  input  logic [N-1:0]  ctsIn,
  input  logic [N-1:0]  dsrIn,
  input  logic [N-1:0]  cdIn,
  input  logic [2*N-1:0] trigSel,
  input  logic [N-1:0]  srcIntEn,
  input  logic [N-1:0]  rxIntEn,
  input  logic [N-1:0]  modemIntEn,
  input  logic [N-1:0]  txIntEn,
  input  logic [SW-1:0] idSel,
  input  ctrlStrobes_t  strb,
  output idFlags_t      idData,
  output logic [N-1:0]  groupStatus
);
  localparam int HALF_MARK  = (DEPTH + 1) / 2;
  localparam int SEVEN_MARK = ((DEPTH + 1) / 8) * 7;

  idFlags_t flagsQ [N];

  for (genvar c = 0; c < N; c++) begin : g_chan
    logic [CW-1:0] lvl;
    trigCode_t     trig;
    logic          reach;
    logic          ctsEdge, dsrEdge, cdEdge;
    logic          clr;

    assign lvl  = rxLevel[c*CW +: CW];
    assign trig = trigCode_t'(trigSel[c*2 +: 2]);
    assign clr  = strb.clearChanges && (idSel == SW'(c));

    always_comb begin
      unique case (trig)
        TRIG_NONE:  reach = 1'b0;
        TRIG_ONE:   reach = (lvl != '0);
        TRIG_HALF:  reach = (lvl >= CW'(HALF_MARK));
        TRIG_SEVEN: reach = (lvl >= CW'(SEVEN_MARK));
        default:    reach = 1'b0;
      endcase
    end

    intid_line_watch u_cts (.clk(clk), .rstN(rstN), .lineIn(ctsIn[c]), .edgeSeen(ctsEdge));
    intid_line_watch u_dsr (.clk(clk), .rstN(rstN), .lineIn(dsrIn[c]), .edgeSeen(dsrEdge));
    intid_line_watch u_cd  (.clk(clk), .rstN(rstN), .lineIn(cdIn[c]),  .edgeSeen(cdEdge));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagsQ[c] <= '0;
      end else begin
        flagsQ[c].rxTrig <= reach;
        flagsQ[c].txMt   <= txEmpty[c];
        flagsQ[c].srcHit <= srcCond[c];
        flagsQ[c].cdChg  <= cdEdge  | (flagsQ[c].cdChg  & ~clr);
        flagsQ[c].ctsChg <= ctsEdge | (flagsQ[c].ctsChg & ~clr);
        flagsQ[c].dsrChg <= dsrEdge | (flagsQ[c].dsrChg & ~clr);
      end
    end

    assign groupStatus[c] = (flagsQ[c].rxTrig & rxIntEn[c])
                          | (flagsQ[c].txMt   & txIntEn[c])
                          | (flagsQ[c].srcHit & srcIntEn[c])
                          | ((flagsQ[c].cdChg | flagsQ[c].ctsChg | flagsQ[c].dsrChg)
                             & modemIntEn[c]);

    // R1: code 0 never yields a receive trigger
    assert_trig_off_R1: assert property (@(posedge clk) disable iff (!rstN)
      flagsQ[c].rxTrig |-> ($past(trigSel[c*2 +: 2]) != 2'b00));
    // R5: a detected CD edge sets the flag
    assert_cd_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
      cdEdge |=> flagsQ[c].cdChg);
    // R6: acknowledge without a fresh edge clears the CTS change flag
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
      (clr && !ctsEdge) |=> !flagsQ[c].ctsChg);
    // R4: transmit-empty flag tracks its input with one clock of delay
    assert_tx_level_R4: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (flagsQ[c].txMt == $past(txEmpty[c])));
  end

  assign idData = flagsQ[idSel];

endmodule

// File: rtl/intid_control.sv
module intid_control
  import intid_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         idRead,
  input  logic         hostEn,
  input  logic         eoiStrobe,
  input  logic         anyPending,
  output ctrlStrobes_t strb,
  output logic         hostIrq
);
  assign strb.clearChanges = idRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   hostIrq <= 1'b0;
    else if (!hostEn || eoiStrobe) hostIrq <= 1'b0;
    else if (anyPending)         hostIrq <= 1'b1;
  end

  // R9: end-of-interrupt drops the line
  assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    eoiStrobe |=> !hostIrq);
  // R8: gate off keeps the line low
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hostEn |=> !hostIrq);
  // R8: pending cause with gate on raises the line
  assert_raise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostEn && !eoiStrobe && anyPending) |=> hostIrq);

endmodule

// File: rtl/chan_int_ident.sv
module chan_int_ident
  import intid_pkg::*;
#(
  parameter int N     = 8,
  parameter int DEPTH = 1023,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N*CW-1:0] rxLevel,
  input  logic [N-1:0]    txEmpty,
  input  logic [N-1:0]    srcCond,
  input  logic [N-1:0]    ctsIn,
  input  logic [N-1:0]    dsrIn,
  input  logic [N-1:0]    cdIn,
  input  logic [2*N-1:0]  trigSel,
  input  logic [N-1:0]    srcIntEn,
  input  logic [N-1:0]    rxIntEn,
  input  logic [N-1:0]    modemIntEn,
  input  logic [N-1:0]    txIntEn,
  input  logic [SW-1:0]   idSel,
  input  logic            idRead,
  output logic [5:0]      idData,
  output logic [N-1:0]    groupStatus,
  input  logic            hostEn,
  input  logic            eoiStrobe,
  output logic            hostIrq
);
  ctrlStrobes_t strb;
  idFlags_t     idWord;

  intid_control u_ctrl (
    .clk(clk), .rstN(rstN), .idRead(idRead), .hostEn(hostEn),
    .eoiStrobe(eoiStrobe), .anyPending(|groupStatus),
    .strb(strb), .hostIrq(hostIrq)
  );

  intid_datapath #(.N(N), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .txEmpty(txEmpty),
    .srcCond(srcCond), .ctsIn(ctsIn), .dsrIn(dsrIn), .cdIn(cdIn),
    .trigSel(trigSel), .srcIntEn(srcIntEn), .rxIntEn(rxIntEn),
    .modemIntEn(modemIntEn), .txIntEn(txIntEn), .idSel(idSel),
    .strb(strb), .idData(idWord), .groupStatus(groupStatus)
  );

  assign idData = idWord;

endmodule

// File: tb/chan_int_ident_bench.sv
module chan_int_ident_bench;
  localparam int N = 8;
  localparam int DEPTH = 1023;
  localparam int CW = 10;
  localparam int SW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N*CW-1:0] rxLevel = '0;
  logic [N-1:0] txEmpty = '0, srcCond = '0, ctsIn = '0, dsrIn = '0, cdIn = '0;
  logic [2*N-1:0] trigSel = '0;
  logic [N-1:0] srcIntEn = '0, rxIntEn = '0, modemIntEn = '0, txIntEn = '0;
  logic [SW-1:0] idSel = '0;
  logic idRead = 1'b0, hostEn = 1'b0, eoiStrobe = 1'b0;
  logic [5:0] idData;
  logic [N-1:0] groupStatus;
  logic hostIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_int_ident #(.N(N), .DEPTH(DEPTH)) u_chan_int_ident (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .txEmpty(txEmpty),
    .srcCond(srcCond), .ctsIn(ctsIn), .dsrIn(dsrIn), .cdIn(cdIn),
    .trigSel(trigSel), .srcIntEn(srcIntEn), .rxIntEn(rxIntEn),
    .modemIntEn(modemIntEn), .txIntEn(txIntEn), .idSel(idSel),
    .idRead(idRead), .idData(idData), .groupStatus(groupStatus),
    .hostEn(hostEn), .eoiStrobe(eoiStrobe), .hostIrq(hostIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic peek(input int ch, output logic [5:0] w);
    idSel = SW'(ch);
    #1;
    w = idData;
  endtask

  task automatic ack(input int ch);
    idSel = SW'(ch);
    idRead = 1'b1;
    tick();
    idRead = 1'b0;
  endtask

  function automatic int expTrig(input int code, input int cnt);
    case (code)
      1: return (cnt >= 1) ? 1 : 0;
      2: return (cnt >= (DEPTH + 1) / 2) ? 1 : 0;
      3: return (cnt >= (DEPTH + 1) * 7 / 8) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int pts [10] = '{0, 1, 2, 511, 512, 513, 895, 896, 897, 1023};
    logic [5:0] w;
    @(negedge clk);
    tick(2);
    // R10: reset state
    for (int c = 0; c < N; c++) begin
      peek(c, w);
      check("R10 flags", w, 0);
    end
    check("R10 group", groupStatus, 0);
    check("R10 irq", hostIrq, 0);
    rstN = 1'b1;
    tick(2);

    // R1/R2: threshold sweep, receive enable off
    for (int code = 0; code < 4; code++) begin
      for (int i = 0; i < 10; i++) begin
        for (int c = 0; c < N; c++) begin
          rxLevel[c*CW +: CW] = CW'(pts[(i + c) % 10]);
          trigSel[c*2 +: 2] = 2'(code);
        end
        tick();
        for (int c = 0; c < N; c++) begin
          peek(c, w);
          check("R1 R2 R3 trigger bit5", w, expTrig(code, pts[(i + c) % 10]) << 5);
        end
        check("R2 R7 group gated", groupStatus, 0);
      end
    end
    rxLevel = '0;
    trigSel = '0;
    tick();

    // R3/R4: level causes
    txEmpty[2] = 1'b1;
    srcCond[5] = 1'b1;
    tick();
    peek(2, w); check("R3 R4 tx empty bit4", w, 6'h10);
    peek(5, w); check("R3 R4 special bit3", w, 6'h08);
    ack(2);
    peek(2, w); check("R4 tx survives read", w, 6'h10);
    txEmpty[2] = 1'b0;
    srcCond[5] = 1'b0;
    tick();
    peek(2, w); check("R4 tx clears", w, 0);
    peek(5, w); check("R4 special clears", w, 0);

    // R5/R6: modem edges, both directions
    ctsIn[1] = 1'b1;
    tick(2);
    peek(1, w); check("R5 cts not yet", w, 0);
    tick();
    peek(1, w); check("R5 R3 cts rise bit1", w, 6'h02);
    ack(1);
    peek(1, w); check("R6 cts cleared", w, 0);
    ctsIn[1] = 1'b0;
    tick(3);
    peek(1, w); check("R5 cts fall", w, 6'h02);
    ack(1);
    dsrIn[1] = 1'b1;
    tick(3);
    peek(1, w); check("R5 R3 dsr bit0", w, 6'h01);
    ack(1);
    cdIn[3] = 1'b1;
    cdIn[4] = 1'b1;
    txEmpty[3] = 1'b1;
    tick(3);
    peek(3, w); check("R5 R3 cd bit2", w, 6'h14);
    ack(3);
    peek(3, w); check("R6 cd cleared, tx kept", w, 6'h10);
    peek(4, w); check("R6 other channel kept", w, 6'h04);
    ack(4);
    txEmpty[3] = 1'b0;
    tick();

    // R7: enable sweep on channel 6
    rxLevel[6*CW +: CW] = CW'(1);
    trigSel[6*2 +: 2] = 2'd1;
    txEmpty[6] = 1'b1;
    srcCond[6] = 1'b1;
    ctsIn[6] = 1'b1;
    tick(3);
    for (int en = 0; en < 16; en++) begin
      rxIntEn[6] = en[0];
      txIntEn[6] = en[1];
      srcIntEn[6] = en[2];
      modemIntEn[6] = en[3];
      #1;
      check("R7 group enable sweep", groupStatus, (en != 0) ? 32'h40 : 0);
    end
    // per-source isolation on channel 0 with only tx empty
    txEmpty[0] = 1'b1;
    rxIntEn[0] = 1'b1; srcIntEn[0] = 1'b1; modemIntEn[0] = 1'b1;
    tick();
    check("R7 wrong enables", groupStatus[0], 0);
    txIntEn[0] = 1'b1;
    #1;
    check("R7 tx enable", groupStatus[0], 1);
    txEmpty[0] = 1'b0;
    rxIntEn[0] = 0; srcIntEn[0] = 0; modemIntEn[0] = 0; txIntEn[0] = 0;
    tick();

    // R8/R9: host line (channel 6 still pending with all enables)
    check("R8 gated off", hostIrq, 0);
    hostEn = 1'b1;
    tick();
    check("R8 raised", hostIrq, 1);
    eoiStrobe = 1'b1;
    tick();
    eoiStrobe = 1'b0;
    check("R9 eoi clears", hostIrq, 0);
    tick();
    check("R9 reasserts pending", hostIrq, 1);
    rxIntEn[6] = 0; txIntEn[6] = 0; srcIntEn[6] = 0; modemIntEn[6] = 0;
    tick(2);
    check("R9 sticky without causes", hostIrq, 1);
    eoiStrobe = 1'b1;
    tick();
    eoiStrobe = 1'b0;
    tick();
    check("R9 stays low after eoi", hostIrq, 0);
    modemIntEn[6] = 1'b1;
    tick();
    check("R8 raised again", hostIrq, 1);
    hostEn = 1'b0;
    tick();
    check("R8 enable off clears", hostIrq, 0);

    finish_run();
  end

endmodule